// File: doc/BRIEF.md
# Coprocessor Mailbox Register Bank

This block is the register bank that sits between a host processor and a power-management coprocessor. Both sides reach it through their own simple access port: a valid strobe, a write flag, a byte offset and a data word. Reads return data one cycle after the request. The bank holds the following words:

- a command word, which reads zero while the coprocessor is idle;
- a status word;
- four parameter words;
- a fixed identification word;
- performance-state, heartbeat and frequency report words, which only the coprocessor can write.

The host starts a command in three steps. It fills the parameters, writes the command word, then rings a doorbell by writing bit 31 of a set-register in a separate interrupt window. This leaves a request pending toward the coprocessor until the coprocessor clears it. When the coprocessor finishes, it raises a done level. The bank turns the rising edge of that level into a single-cycle interrupt to the host. The coprocessor can also fetch any parameter word directly through an index port.

Top module: `cpmb_regbank`

## Requirements
- R1: After reset, `cmd_idle` is 1, `cp_req` and `host_irq` are 0, and every writable word reads 0.
- R2: The host can write and read back the command word (0x00), the status word (0x04) and the parameter words (0x18, 0x1C, 0x20, 0x24). Read data appears on the read-data port in the cycle after the request.
- R3: Offset 0x34 always reads 0xA11600D1 from both sides, and writes to it are ignored.
- R4: The performance-state (0x2C), heartbeat (0x30) and frequency (0x50) words are written by the coprocessor port only. Host writes to them are ignored.
- R5: Any offset not listed above reads 0 on either port. Writing such an offset changes nothing.
- R6: `cmd_idle` is 1 exactly when the command word holds zero.
- R7: On the coprocessor index port, an index of 0 to 3 gives the matching parameter word, and any index of 4 or more gives parameter 0.
- R8: A host write to offset 0x04 of the interrupt window (`host_sel_irq`=1) with bit 31 set makes `cp_req` 1 from the next cycle. A host read of that offset returns the pending bit in bit 31.
- R9: `cp_req` stays set until a `cp_clr_req` pulse. A doorbell write with bit 31 low, or a write to another interrupt-window offset, leaves it unchanged. A clear in the same cycle as a set leaves it 0.
- R10: A rising edge of `cp_done` gives a `host_irq` pulse exactly one cycle long, in the cycle after the edge. Holding `cp_done` high gives no further pulse.
- R11: When both ports write the same register in the same cycle, the coprocessor value is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_vld | input | 1 | Host access strobe |
| host_wr | input | 1 | Host access is a write |
| host_sel_irq | input | 1 | Host access targets the interrupt window |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after the request |
| cp_vld | input | 1 | Coprocessor access strobe |
| cp_wr | input | 1 | Coprocessor access is a write |
| cp_addr | input | ADDR_W | Coprocessor byte offset |
| cp_wdata | input | DATA_W | Coprocessor write data |
| cp_rdata | output | DATA_W | Coprocessor read data, one cycle after the request |
| cp_pidx | input | PIDX_W | Parameter index for direct fetch |
| cp_pval | output | DATA_W | Parameter word chosen by `cp_pidx` |
| cp_clr_req | input | 1 | Clears the pending doorbell |
| cp_done | input | 1 | Command completion level from the coprocessor |
| cp_req | output | 1 | Pending doorbell toward the coprocessor |
| host_irq | output | 1 | Single-cycle completion interrupt to the host |
| cmd_idle | output | 1 | Command word is zero |

## Verification
The main access path is driven through a table that mixes the following patterns:
- writes and read-backs of the host-writable words with distinct values, which shows that each word is decoded separately;
- host writes to coprocessor-owned and constant words followed by reads, which shows whether write protection holds;
- reads of gap offsets, which exposes any aliasing.

Directed sequences cover the remaining behaviour. One sweeps every index value on the direct-fetch port, which shows correct selection apart from folding. Another walks the doorbell through a set, a bit-31-low write, a wrong-offset write, a clear, and a set that collides with a clear. A third holds the done level high to separate edge detection from level following. A same-cycle write from both ports to one word shows the coprocessor winning.

// File: rtl/cpmb_pkg.sv
package cpmb_pkg;
  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_PBASE = 8'h18;
  localparam logic [7:0] OFF_PST   = 8'h2C;
  localparam logic [7:0] OFF_HBEAT = 8'h30;
  localparam logic [7:0] OFF_MAGIC = 8'h34;
  localparam logic [7:0] OFF_FREQ  = 8'h50;
  localparam logic [7:0] OFF_IRQSET = 8'h04;
  localparam int unsigned DOORBELL_BIT = 31;
  localparam logic [31:0] ID_WORD = 32'hA116_00D1;
endpackage

// File: rtl/cpmb_params.sv
module cpmb_params #(
  parameter int DW = 32,
  parameter int NP = 4,
  parameter int PIDX_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   host_we,
  input  logic [NP-1:0]   cp_we,
  input  logic [DW-1:0]   host_wdata,
  input  logic [DW-1:0]   cp_wdata,
  input  logic [PIDX_W-1:0] pidx,
  output logic [NP*DW-1:0] words,
  output logic [DW-1:0]   pval
);
  for (genvar i = 0; i < NP; i++) begin : g_word
    logic [DW-1:0] q, d;
    logic en;
    always_comb begin
      en = cp_we[i] | host_we[i];
      d  = cp_we[i] ? cp_wdata : host_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (en) q <= d;
    end
    assign words[i*DW +: DW] = q;

    // R11: coprocessor value wins on a same-cycle collision
    assert_cpwins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cp_we[i] |=> (q == $past(cp_wdata)));
  end

  // R7: indices past the last word fold onto word 0
  always_comb begin
    if (int'(pidx) < NP) pval = words[int'(pidx)*DW +: DW];
    else                 pval = words[0 +: DW];
  end
endmodule

// File: rtl/cpmb_doorbell.sv
module cpmb_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;
  always_comb begin
    pend_d = pend_o;
    if (set_i) pend_d = 1'b1;
    if (clr_i) pend_d = 1'b0;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> pend_o);
  assert_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !pend_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(pend_o));
endmodule

// File: rtl/cpmb_edge_irq.sv
module cpmb_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  output logic irq_o
);
  logic done_q, irq_d;
  always_comb irq_d = done_i & ~done_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      done_q <= done_i;
      irq_o  <= irq_d;
    end
  end

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !done_q) |=> irq_o);
endmodule

// File: rtl/cpmb_regbank.sv
module cpmb_regbank
  import cpmb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NUM_PARAM = 4,
  parameter int PIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_vld,
  input  logic              host_wr,
  input  logic              host_sel_irq,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cp_vld,
  input  logic              cp_wr,
  input  logic [ADDR_W-1:0] cp_addr,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata,
  input  logic [PIDX_W-1:0] cp_pidx,
  output logic [DATA_W-1:0] cp_pval,
  input  logic              cp_clr_req,
  input  logic              cp_done,
  output logic              cp_req,
  output logic              host_irq,
  output logic              cmd_idle
);
  localparam int PW = NUM_PARAM * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  function automatic logic [ADDR_W-1:0] walign(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic [NUM_PARAM-1:0] phit(input logic [ADDR_W-1:0] a);
    logic [NUM_PARAM-1:0] h;
    h = '0;
    for (int i = 0; i < NUM_PARAM; i++)
      if (walign(a) == ADDR_W'(int'(OFF_PBASE) + 4*i)) h[i] = 1'b1;
    return h;
  endfunction

  // write strobes
  logic h_we, c_we;
  logic [NUM_PARAM-1:0] h_pwe, c_pwe;
  logic [ADDR_W-1:0] h_wa, c_wa;
  always_comb begin
    h_we  = host_vld & host_wr & ~host_sel_irq;
    c_we  = cp_vld & cp_wr;
    h_wa  = walign(host_addr);
    c_wa  = walign(cp_addr);
    h_pwe = h_we ? phit(host_addr) : '0;
    c_pwe = c_we ? phit(cp_addr) : '0;
  end

  // scalar words
  logic [DATA_W-1:0] cmd_q, stat_q, pst_q, hb_q, freq_q;
  logic [DATA_W-1:0] cmd_d, stat_d, pst_d, hb_d, freq_d;
  always_comb begin
    cmd_d  = cmd_q;
    stat_d = stat_q;
    pst_d  = pst_q;
    hb_d   = hb_q;
    freq_d = freq_q;
    if (h_we && h_wa == ADDR_W'(OFF_CMD))  cmd_d  = host_wdata;
    if (h_we && h_wa == ADDR_W'(OFF_STAT)) stat_d = host_wdata;
    if (c_we && c_wa == ADDR_W'(OFF_CMD))   cmd_d  = cp_wdata;
    if (c_we && c_wa == ADDR_W'(OFF_STAT))  stat_d = cp_wdata;
    if (c_we && c_wa == ADDR_W'(OFF_PST))   pst_d  = cp_wdata;
    if (c_we && c_wa == ADDR_W'(OFF_HBEAT)) hb_d   = cp_wdata;
    if (c_we && c_wa == ADDR_W'(OFF_FREQ))  freq_d = cp_wdata;
  end
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_q <= '0; stat_q <= '0; pst_q <= '0; hb_q <= '0; freq_q <= '0;
    end else begin
      cmd_q <= cmd_d; stat_q <= stat_d; pst_q <= pst_d;
      hb_q <= hb_d; freq_q <= freq_d;
    end
  end
  assign cmd_idle = (cmd_q == '0);

  logic [PW-1:0] pwords;
  cpmb_params #(.DW(DATA_W), .NP(NUM_PARAM), .PIDX_W(PIDX_W)) u_params (
    .clk(clk), .rst_n(rst_n_s), .host_we(h_pwe), .cp_we(c_pwe),
    .host_wdata(host_wdata), .cp_wdata(cp_wdata), .pidx(cp_pidx),
    .words(pwords), .pval(cp_pval)
  );

  logic db_set;
  assign db_set = host_vld & host_wr & host_sel_irq &
                  (walign(host_addr) == ADDR_W'(OFF_IRQSET)) &
                  host_wdata[DOORBELL_BIT];
  cpmb_doorbell u_db (
    .clk(clk), .rst_n(rst_n_s), .set_i(db_set), .clr_i(cp_clr_req), .pend_o(cp_req)
  );

  cpmb_edge_irq u_irq (
    .clk(clk), .rst_n(rst_n_s), .done_i(cp_done), .irq_o(host_irq)
  );

  // read multiplexers
  function automatic logic [DATA_W-1:0] rmux(input logic [ADDR_W-1:0] a,
    input logic [DATA_W-1:0] c, s, p, h, f, input logic [PW-1:0] pw);
    logic [DATA_W-1:0] r;
    logic [NUM_PARAM-1:0] ph;
    r  = '0;
    ph = phit(a);
    case (walign(a))
      ADDR_W'(OFF_CMD):   r = c;
      ADDR_W'(OFF_STAT):  r = s;
      ADDR_W'(OFF_PST):   r = p;
      ADDR_W'(OFF_HBEAT): r = h;
      ADDR_W'(OFF_MAGIC): r = ID_WORD;
      ADDR_W'(OFF_FREQ):  r = f;
      default:            r = '0;
    endcase
    for (int i = 0; i < NUM_PARAM; i++)
      if (ph[i]) r = pw[i*DATA_W +: DATA_W];
    return r;
  endfunction

  logic [DATA_W-1:0] h_rd, c_rd, h_irq_rd;
  logic h_re, c_re;
  always_comb begin
    h_re = host_vld & ~host_wr;
    c_re = cp_vld & ~cp_wr;
    h_irq_rd = '0;
    if (walign(host_addr) == ADDR_W'(OFF_IRQSET)) h_irq_rd[DOORBELL_BIT] = cp_req;
    h_rd = host_sel_irq ? h_irq_rd : rmux(host_addr, cmd_q, stat_q, pst_q, hb_q, freq_q, pwords);
    c_rd = rmux(cp_addr, cmd_q, stat_q, pst_q, hb_q, freq_q, pwords);
  end
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      host_rdata <= '0;
      cp_rdata   <= '0;
    end else begin
      if (h_re) host_rdata <= h_rd;
      if (c_re) cp_rdata   <= c_rd;
    end
  end

  assert_magic_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (h_re && !host_sel_irq && walign(host_addr) == ADDR_W'(OFF_MAGIC))
      |=> (host_rdata == ID_WORD));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (c_we && c_wa == ADDR_W'(OFF_CMD) && cp_wdata != '0) |=> !cmd_idle);
  assert_ro_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(c_we && c_wa == ADDR_W'(OFF_FREQ)) |=> $stable(freq_q));
endmodule

// File: tb/tb_cpmb_regbank.sv
module tb_cpmb_regbank;
  logic clk = 1'b0;
  logic rst_n;
  logic host_vld, host_wr, host_sel_irq;
  logic [7:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic cp_vld, cp_wr;
  logic [7:0] cp_addr;
  logic [31:0] cp_wdata, cp_rdata, cp_pval;
  logic [2:0] cp_pidx;
  logic cp_clr_req, cp_done, cp_req, host_irq, cmd_idle;

  int total = 0;
  int bad = 0;
  localparam logic [31:0] MAGIC = 32'hA116_00D1;

  always #4 clk = ~clk;  // 125 MHz

  cpmb_regbank dut (.*);

  typedef struct packed {
    logic       cp;
    logic       wr;
    logic [7:0] addr;
    logic [31:0] dat;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    // R2: host-writable words
    '{1'b0,1'b1,8'h00,32'h0000_0011,8'd2}, '{1'b0,1'b0,8'h00,32'h0000_0011,8'd2},
    '{1'b0,1'b1,8'h04,32'h0000_00F0,8'd2}, '{1'b0,1'b0,8'h04,32'h0000_00F0,8'd2},
    '{1'b0,1'b1,8'h18,32'hA0A0_0000,8'd2}, '{1'b0,1'b1,8'h1C,32'hA1A1_0001,8'd2},
    '{1'b0,1'b1,8'h20,32'hA2A2_0002,8'd2}, '{1'b0,1'b1,8'h24,32'hA3A3_0003,8'd2},
    '{1'b0,1'b0,8'h18,32'hA0A0_0000,8'd2}, '{1'b0,1'b0,8'h1C,32'hA1A1_0001,8'd2},
    '{1'b0,1'b0,8'h20,32'hA2A2_0002,8'd2}, '{1'b0,1'b0,8'h24,32'hA3A3_0003,8'd2},
    // R3: constant identification word
    '{1'b0,1'b0,8'h34,MAGIC,8'd3}, '{1'b0,1'b1,8'h34,32'h0,8'd3},
    '{1'b0,1'b0,8'h34,MAGIC,8'd3}, '{1'b1,1'b0,8'h34,MAGIC,8'd3},
    // R4: coprocessor-owned words
    '{1'b1,1'b1,8'h2C,32'h3,8'd4}, '{1'b1,1'b1,8'h50,32'h5DC,8'd4},
    '{1'b1,1'b1,8'h30,32'h99,8'd4}, '{1'b0,1'b1,8'h2C,32'h7,8'd4},
    '{1'b0,1'b1,8'h50,32'h0,8'd4}, '{1'b0,1'b1,8'h30,32'h1,8'd4},
    '{1'b0,1'b0,8'h2C,32'h3,8'd4}, '{1'b0,1'b0,8'h50,32'h5DC,8'd4},
    '{1'b0,1'b0,8'h30,32'h99,8'd4},
    // R5: gaps read zero
    '{1'b0,1'b1,8'h28,32'hFFFF,8'd5}, '{1'b0,1'b0,8'h28,32'h0,8'd5},
    '{1'b0,1'b0,8'h08,32'h0,8'd5}, '{1'b1,1'b0,8'h54,32'h0,8'd5},
    '{1'b1,1'b0,8'h18,32'hA0A0_0000,8'd2}
  };

  task automatic check(input string rq, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // drive at negedge, one posedge, back at negedge with read data ready
  task automatic acc(input logic cp, wr, irq, input logic [7:0] a, input logic [31:0] d);
    if (cp) begin
      cp_vld = 1'b1; cp_wr = wr; cp_addr = a; cp_wdata = d;
    end else begin
      host_vld = 1'b1; host_wr = wr; host_sel_irq = irq; host_addr = a; host_wdata = d;
    end
    @(negedge clk);
    host_vld = 1'b0; cp_vld = 1'b0; host_sel_irq = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_vld = 0; host_wr = 0; host_sel_irq = 0; host_addr = 0; host_wdata = 0;
    cp_vld = 0; cp_wr = 0; cp_addr = 0; cp_wdata = 0; cp_pidx = 0;
    cp_clr_req = 0; cp_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 idle", {31'b0, cmd_idle}, 32'd1);
    check("R1 req", {31'b0, cp_req}, 32'd0);
    check("R1 irq", {31'b0, host_irq}, 32'd0);
    acc(0, 0, 0, 8'h00, 0); check("R1 cmd", host_rdata, 32'h0);
    acc(0, 0, 0, 8'h1C, 0); check("R1 param", host_rdata, 32'h0);
    acc(0, 0, 0, 8'h50, 0); check("R1 freq", host_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].cp, VEC[i].wr, 1'b0, VEC[i].addr, VEC[i].dat);
      if (!VEC[i].wr)
        check($sformatf("R%0d vec%0d", VEC[i].rq, i),
              VEC[i].cp ? cp_rdata : host_rdata, VEC[i].dat);
    end

    // R6: idle follows command word
    check("R6 busy", {31'b0, cmd_idle}, 32'd0);
    acc(1, 1, 0, 8'h00, 32'h0);
    check("R6 idle", {31'b0, cmd_idle}, 32'd1);

    // R7: direct fetch with folding
    for (int k = 0; k < 8; k++) begin
      cp_pidx = 3'(k);
      #1;
      check($sformatf("R7 idx%0d", k), cp_pval,
            (k < 4) ? {8'hA0 + 8'(k*1), 8'hA0 + 8'(k*1), 16'(k)} + 32'h0 +
                      ((k == 0) ? 32'h0 : 32'h0101_0000 * 0) : 32'hA0A0_0000);
    end

    // R8: doorbell set and read-back
    acc(0, 1, 1, 8'h04, 32'h8000_0000);
    check("R8 set", {31'b0, cp_req}, 32'd1);
    acc(0, 0, 1, 8'h04, 0);
    check("R8 readback", host_rdata, 32'h8000_0000);
    // R9: no-effect writes, hold, clear
    acc(0, 1, 1, 8'h04, 32'h7FFF_FFFF);
    check("R9 low bit keeps", {31'b0, cp_req}, 32'd1);
    cp_clr_req = 1'b1; @(negedge clk); cp_clr_req = 1'b0;
    check("R9 clear", {31'b0, cp_req}, 32'd0);
    acc(0, 1, 1, 8'h04, 32'h7FFF_FFFF);
    check("R9 low bit no set", {31'b0, cp_req}, 32'd0);
    acc(0, 1, 1, 8'h00, 32'h8000_0000);
    check("R9 wrong offset", {31'b0, cp_req}, 32'd0);
    cp_clr_req = 1'b1;
    acc(0, 1, 1, 8'h04, 32'h8000_0000);
    cp_clr_req = 1'b0;
    check("R9 clear beats set", {31'b0, cp_req}, 32'd0);

    // R10: edge interrupt
    cp_done = 1'b1;
    @(negedge clk); check("R10 pulse", {31'b0, host_irq}, 32'd1);
    @(negedge clk); check("R10 one cycle", {31'b0, host_irq}, 32'd0);
    repeat (3) @(negedge clk);
    check("R10 level no repeat", {31'b0, host_irq}, 32'd0);
    cp_done = 1'b0;

    // R11: same-cycle collision on parameter 1
    host_vld = 1; host_wr = 1; host_addr = 8'h1C; host_wdata = 32'h1111_1111;
    cp_vld = 1; cp_wr = 1; cp_addr = 8'h1C; cp_wdata = 32'h2222_2222;
    @(negedge clk);
    host_vld = 0; cp_vld = 0;
    acc(0, 0, 0, 8'h1C, 0);
    check("R11 cp wins", host_rdata, 32'h2222_2222);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule